// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block holds the event status word and the interrupt-enable word of an Ethernet MAC DMA, and it drives the single interrupt line of that DMA. The transmit and receive engines are not part of the block. They appear as ports: an event vector whose bits are one-cycle set pulses, and two write strobes that load the 3-bit transmit and receive process-state fields kept in the status word.

Software reaches the two words through a 32-bit register port with a one-bit address. Address 0 is the status word and address 1 is the enable word. Event bits in the status word are cleared by writing ones. Two sticky summary bits gather the enabled events: one for the normal group and one for the abnormal group. The interrupt line follows the enabled summaries with no added register stage. A write that tries to change a read-only status bit leaves it unchanged and pulses an error flag. A write that clears the receive-buffer-unavailable event also puts the receive process state back to its running-waiting code.

Top module: `dma_irq_status`

## Requirements
- R1: Each `evt_set[i]` pulse (i = 0..14) sets status bit i at the next clock edge. When a set and a write-one clear reach the same bit in the same cycle, the set wins.
- R2: A write to address 0 clears every event bit 0..14 whose data bit is 1. Event bits whose data bit is 0 keep their value.
- R3: Status bit 16 (normal summary) becomes 1 at the edge where any of bits 0, 2 or 6 is set with the same-numbered enable bit set. It stays 1 until bit 16 is written with a one, and it sets again at once if such a source is still set and enabled.
- R4: Status bit 15 (abnormal summary) follows the same rules as R3 over event bits 1, 3, 4, 5 and 7..14.
- R5: `irq` equals (status bit 16 AND enable bit 16) OR (status bit 15 AND enable bit 15). It is taken directly from the registers, so it changes at the same edge as the status and enable words.
- R6: Status bits 31..17 cannot be written. A write to address 0 with any of those data bits set leaves them unchanged and drives `ro_err` high for exactly the following cycle. A write to address 1 never raises `ro_err`.
- R7: A `tx_state_we` pulse loads `tx_state_val` into status bits 22:20. A `rx_state_we` pulse loads `rx_state_val` into bits 19:17. Each field keeps its value when its own strobe is low.
- R8: Writing a 1 to status bit 7 (receive buffer unavailable) sets bits 19:17 to 3'b011 (running, waiting). If `rx_state_we` is high in the same cycle, the engine value wins.
- R9: After reset both words read 0, and `irq` and `ro_err` are 0.
- R10: Enable bits 16..0 are written from address 1. Enable bits 31..17 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| ro_err | output | 1 | One-cycle pulse after a write to read-only status bits |
| evt_set | input | 15 | Event set pulses from the engines |
| tx_state_we | input | 1 | Transmit state field load strobe |
| tx_state_val | input | 3 | Transmit state value |
| rx_state_we | input | 1 | Receive state field load strobe |
| rx_state_val | input | 3 | Receive state value |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives several same-cycle collisions on purpose. One is an event and its clear landing on the same bit; a design that lets the clear win drops an event. Another is a clear of a summary bit while its source is still set and enabled; a design that does not set the summary again leaves the interrupt low while an event is still pending. A third is an unavailable-bit clear together with an engine state write; with the wrong priority, the waiting code overwrites the engine state. The bench also enables a summary without its source bits, and the reverse, to find an interrupt that ignores one of the two enable levels. It writes the read-only bits to catch a design that stores them or fails to flag the write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int REG_W = 32;

   // Process-state codes shared by both engines.
   typedef enum logic [2:0] {
      PS_STOP  = 3'd0,
      PS_FETCH = 3'd1,
      PS_WAIT  = 3'd3,
      PS_SUSP  = 3'd4,
      PS_CLOSE = 3'd5,
      PS_XFER  = 3'd7
   } proc_state_e;
endpackage

// File: rtl/dma_evt_bank.sv
module dma_evt_bank #(
   parameter int N = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] ev_q,
   output logic [N-1:0] ev_nx
);
   // A set always beats a clear on the same bit.
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign ev_nx[i] = set_i[i] | (ev_q[i] & ~clr_i[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= ev_nx;
   end
endmodule

// File: rtl/dma_summary.sv
module dma_summary #(
   parameter int           N    = 15,
   parameter logic [N-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_nx,
   input  logic [N-1:0] en_nx,
   input  logic         clr_i,
   output logic         sum_q
);
   logic hit;
   assign hit = |(ev_nx & en_nx & MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= 1'b0;
      else        sum_q <= hit | (sum_q & ~clr_i);
   end
endmodule

// File: rtl/dma_state_field.sv
module dma_state_field #(
   parameter int           W        = 3,
   parameter bit           HAS_KICK = 1'b0,
   parameter logic [W-1:0] KICK_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] val_i,
   input  logic         kick_i,
   output logic [W-1:0] state_q
);
   logic [W-1:0] state_nx;

   if (HAS_KICK) begin : g_kick
      // The engine write has priority over the software kick.
      always_comb begin
         if (we_i)        state_nx = val_i;
         else if (kick_i) state_nx = KICK_VAL;
         else             state_nx = state_q;
      end
   end else begin : g_plain
      logic unused_kick;
      assign unused_kick = kick_i;
      assign state_nx = we_i ? val_i : state_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_nx;
   end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_irq_pkg::*;
#(
   parameter int                  EVT_BITS  = 15,
   parameter logic [EVT_BITS-1:0] NORM_MASK = 15'h0045,
   parameter int                  AIS_BIT   = 15,
   parameter int                  NIS_BIT   = 16,
   parameter int                  RX_LSB    = 17,
   parameter int                  TX_LSB    = 20,
   parameter int                  STATE_W   = 3,
   parameter int                  RU_BIT    = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                ro_err,
   input  logic [EVT_BITS-1:0] evt_set,
   input  logic                tx_state_we,
   input  logic [STATE_W-1:0]  tx_state_val,
   input  logic                rx_state_we,
   input  logic [STATE_W-1:0]  rx_state_val,
   output logic                irq
);
   localparam logic [EVT_BITS-1:0] ABN_MASK  = ~NORM_MASK;
   localparam logic [REG_W-1:0]    EVT_FIELD = {{(REG_W-EVT_BITS){1'b0}}, {EVT_BITS{1'b1}}};
   localparam logic [REG_W-1:0]    SUM_FIELD = (REG_W'(1) << AIS_BIT) | (REG_W'(1) << NIS_BIT);
   localparam logic [REG_W-1:0]    EN_WMASK  = EVT_FIELD | SUM_FIELD;
   localparam logic [REG_W-1:0]    RO_MASK   = ~EN_WMASK;
   localparam logic [STATE_W-1:0]  RX_WAIT   = STATE_W'(PS_WAIT);

   // Elaboration-time parameter checks
   if (AIS_BIT < EVT_BITS || NIS_BIT < EVT_BITS || AIS_BIT == NIS_BIT) begin : g_bad_sum
      $error("summary bits overlap the event field");
   end
   if (RX_LSB <= NIS_BIT || RX_LSB <= AIS_BIT || RX_LSB + STATE_W > TX_LSB) begin : g_bad_rx
      $error("receive state field misplaced");
   end
   if (TX_LSB + STATE_W > REG_W) begin : g_bad_tx
      $error("transmit state field exceeds register width");
   end
   if (RU_BIT >= EVT_BITS) begin : g_bad_ru
      $error("unavailable bit outside the event field");
   end

   // Write decode
   logic                wr_status, wr_enable;
   logic [EVT_BITS-1:0] evt_clr;
   assign wr_status = reg_wr & ~reg_addr;
   assign wr_enable = reg_wr &  reg_addr;
   assign evt_clr   = wr_status ? reg_wdata[EVT_BITS-1:0] : '0;

   // Enable word
   logic [REG_W-1:0] en_q, en_nx;
   assign en_nx = wr_enable ? (reg_wdata & EN_WMASK) : en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_nx;
   end

   // Event bits
   logic [EVT_BITS-1:0] ev_q, ev_nx;
   dma_evt_bank #(.N(EVT_BITS)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_set),
      .clr_i (evt_clr),
      .ev_q  (ev_q),
      .ev_nx (ev_nx)
   );

   // Summary bits: group 0 normal, group 1 abnormal
   logic [1:0] sum_q;
   for (genvar g = 0; g < 2; g++) begin : g_sum
      localparam logic [EVT_BITS-1:0] GM = (g == 0) ? NORM_MASK : ABN_MASK;
      localparam int                  GP = (g == 0) ? NIS_BIT : AIS_BIT;
      dma_summary #(.N(EVT_BITS), .MASK(GM)) u_sum (
         .clk   (clk),
         .rst_n (rst_n),
         .ev_nx (ev_nx),
         .en_nx (en_nx[EVT_BITS-1:0]),
         .clr_i (wr_status & reg_wdata[GP]),
         .sum_q (sum_q[g])
      );
   end

   logic nis_q, ais_q;
   assign nis_q = sum_q[0];
   assign ais_q = sum_q[1];

   // Process-state fields
   logic [STATE_W-1:0] rx_q, tx_q;
   dma_state_field #(.W(STATE_W), .HAS_KICK(1'b1), .KICK_VAL(RX_WAIT)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (rx_state_we),
      .val_i   (rx_state_val),
      .kick_i  (evt_clr[RU_BIT]),
      .state_q (rx_q)
   );
   dma_state_field #(.W(STATE_W), .HAS_KICK(1'b0), .KICK_VAL('0)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (tx_state_we),
      .val_i   (tx_state_val),
      .kick_i  (1'b0),
      .state_q (tx_q)
   );

   // Read-only write flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ro_err <= 1'b0;
      else        ro_err <= wr_status & (|(reg_wdata & RO_MASK));
   end

   // Read path
   logic [REG_W-1:0] status_w;
   always_comb begin
      status_w                    = '0;
      status_w[EVT_BITS-1:0]      = ev_q;
      status_w[AIS_BIT]           = ais_q;
      status_w[NIS_BIT]           = nis_q;
      status_w[RX_LSB +: STATE_W] = rx_q;
      status_w[TX_LSB +: STATE_W] = tx_q;
   end
   assign reg_rdata = reg_addr ? en_q : status_w;

   assign irq = (nis_q & en_q[NIS_BIT]) | (ais_q & en_q[AIS_BIT]);
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
   parameter int                  EVT_BITS  = 15,
   parameter logic [EVT_BITS-1:0] NORM_MASK = 15'h0045,
   parameter int                  RU_BIT    = 7,
   parameter int                  STATE_W   = 3,
   parameter logic [STATE_W-1:0]  RX_WAIT   = 3'd3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [EVT_BITS-1:0] evt_set,
   input logic [EVT_BITS-1:0] evt_clr,
   input logic                wr_enable,
   input logic [EVT_BITS-1:0] ev_q,
   input logic [EVT_BITS-1:0] en_src,
   input logic                en_nis,
   input logic                en_ais,
   input logic                nis_q,
   input logic                ais_q,
   input logic                tx_state_we,
   input logic                rx_state_we,
   input logic [STATE_W-1:0]  rx_q,
   input logic [STATE_W-1:0]  tx_q,
   input logic                ro_err,
   input logic                irq
);
   for (genvar b = 0; b < EVT_BITS; b++) begin : g_bit
      assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
         evt_set[b] |=> ev_q[b]);
      assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_clr[b] && !evt_set[b]) |=> !ev_q[b]);
   end

   assert_nis_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ev_q & en_src & NORM_MASK)) |-> nis_q);

   assert_ais_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ev_q & en_src & ~NORM_MASK)) |-> ais_q);

   assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!nis_q && !ais_q) |-> !irq);

   assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((nis_q && en_nis) || (ais_q && en_ais)) |-> irq);

   assert_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enable |=> !ro_err);

   assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_state_we |=> $stable(tx_q));

   assert_rx_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr[RU_BIT] && !rx_state_we) |=> (rx_q == RX_WAIT));
endmodule

bind dma_irq_status dma_irq_status_chk #(
   .EVT_BITS  (EVT_BITS),
   .NORM_MASK (NORM_MASK),
   .RU_BIT    (RU_BIT),
   .STATE_W   (STATE_W),
   .RX_WAIT   (RX_WAIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_set     (evt_set),
   .evt_clr     (evt_clr),
   .wr_enable   (wr_enable),
   .ev_q        (ev_q),
   .en_src      (en_q[EVT_BITS-1:0]),
   .en_nis      (en_q[NIS_BIT]),
   .en_ais      (en_q[AIS_BIT]),
   .nis_q       (nis_q),
   .ais_q       (ais_q),
   .tx_state_we (tx_state_we),
   .rx_state_we (rx_state_we),
   .rx_q        (rx_q),
   .tx_q        (tx_q),
   .ro_err      (ro_err),
   .irq         (irq)
);

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ro_err;
   logic [14:0] evt_set = '0;
   logic        tx_we = 1'b0, rx_we = 1'b0;
   logic [2:0]  tx_val = '0, rx_val = '0;
   logic        irq;

   always #(CLK_P/2) clk = ~clk;

   dma_irq_status u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .ro_err       (ro_err),
      .evt_set      (evt_set),
      .tx_state_we  (tx_we),
      .tx_state_val (tx_val),
      .rx_state_we  (rx_we),
      .rx_state_val (rx_val),
      .irq          (irq)
   );

   // Behavioural reference model
   logic [14:0] m_ev = '0;
   logic [31:0] m_en = '0;
   logic [31:0] m_clr;
   logic        m_nis = 1'b0, m_ais = 1'b0, m_err = 1'b0;
   logic [2:0]  m_rx = '0, m_tx = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ev = '0; m_en = '0; m_nis = 1'b0; m_ais = 1'b0;
         m_rx = '0; m_tx = '0; m_err = 1'b0;
      end else begin
         m_clr = (reg_wr && !reg_addr) ? reg_wdata : 32'h0;
         m_err = reg_wr && !reg_addr && (reg_wdata[31:17] != 15'h0);
         m_ev  = (m_ev & ~m_clr[14:0]) | evt_set;
         if (reg_wr && reg_addr) m_en = reg_wdata & 32'h0001_FFFF;
         m_nis = (m_nis && !m_clr[16]) || ((m_ev & m_en[14:0] & 15'h0045) != 15'h0);
         m_ais = (m_ais && !m_clr[15]) || ((m_ev & m_en[14:0] & ~15'h0045) != 15'h0);
         if (rx_we)          m_rx = rx_val;
         else if (m_clr[7])  m_rx = 3'd3;
         if (tx_we)          m_tx = tx_val;
      end
   end

   int    n_chk = 0, n_fail = 0, n_cyc = 0;
   bit    running = 1'b0;
   string cur_req = "R9";

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         check(reg_rdata, reg_addr ? m_en : {9'h0, m_tx, m_rx, m_nis, m_ais, m_ev}, "rdata");
         check({31'h0, irq}, {31'h0, (m_nis & m_en[16]) | (m_ais & m_en[15])}, "irq");
         check({31'h0, ro_err}, {31'h0, m_err}, "ro_err");
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
      reg_wr = 1'b0; evt_set = '0; tx_we = 1'b0; rx_we = 1'b0;
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
   endtask

   task automatic sel(input logic a);
      reg_addr = a;
      cyc();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected at most 50000", n_cyc);
         finish_run();
      end
   end

   initial begin
      @(posedge clk); #1;
      running = 1'b1;
      // R9: reset state on both words
      cur_req = "R9";
      sel(1'b0); sel(1'b1); sel(1'b0);
      rst_n = 1'b1;
      cyc();

      // R10: only enable bits 16..0 stick
      cur_req = "R10";
      wr(1'b1, 32'hFFFF_FFFF); sel(1'b1);
      wr(1'b1, 32'h0); sel(1'b0);

      // R1: event with nothing enabled sets the bit, no interrupt
      cur_req = "R1";
      evt_set = 15'h0001; cyc(); cyc();

      // R3: normal summary and its re-arm behaviour
      cur_req = "R3";
      wr(1'b1, 32'h0001_0001); sel(1'b0);
      wr(1'b0, 32'h0001_0000); cyc();
      wr(1'b0, 32'h0001_0001); cyc();
      evt_set = 15'h0040; cyc();
      wr(1'b1, 32'h0001_0045); sel(1'b0);
      wr(1'b0, 32'h0001_0040); cyc();

      // R4: abnormal summary
      cur_req = "R4";
      wr(1'b1, 32'h0000_8002); sel(1'b0);
      evt_set = 15'h0002; cyc(); cyc();
      evt_set = 15'h4000; cyc();
      wr(1'b1, 32'h0000_C002); sel(1'b0);

      // R2: W1C touches only the ones written
      cur_req = "R2";
      evt_set = 15'h0038; cyc();
      wr(1'b0, 32'h0000_0010); cyc();
      wr(1'b0, 32'h0000_0000); cyc();
      wr(1'b0, 32'h0000_FFFF); cyc();

      // R1: set and clear collide on one bit
      cur_req = "R1";
      evt_set = 15'h0008; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0000_0008; cyc(); cyc();

      // R5: summary set but its enable cleared
      cur_req = "R5";
      wr(1'b1, 32'h0000_0001); sel(1'b0);
      evt_set = 15'h0001; cyc(); cyc();
      wr(1'b1, 32'h0001_0001); sel(1'b0);
      wr(1'b1, 32'h0000_8000); sel(1'b0);
      evt_set = 15'h0100; cyc();
      wr(1'b1, 32'h0000_8100); sel(1'b0);
      wr(1'b0, 32'h0001_FFFF); cyc();

      // R7: engine state fields
      cur_req = "R7";
      tx_we = 1'b1; tx_val = 3'd5; rx_we = 1'b1; rx_val = 3'd2; cyc();
      rx_we = 1'b1; rx_val = 3'd7; cyc();
      tx_we = 1'b1; tx_val = 3'd1; cyc(); cyc();

      // R6: read-only bits
      cur_req = "R6";
      wr(1'b0, 32'hFFFE_0000); cyc(); cyc();
      wr(1'b1, 32'hFFFE_0000); sel(1'b0); cyc();

      // R8: unavailable clear moves the receive state
      cur_req = "R8";
      evt_set = 15'h0080; cyc();
      wr(1'b0, 32'h0000_0080); cyc();
      rx_we = 1'b1; rx_val = 3'd4; cyc();
      evt_set = 15'h0080; cyc();
      rx_we = 1'b1; rx_val = 3'd6; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0000_0080; cyc(); cyc();

      // R5: mixed traffic against the model
      cur_req = "R5";
      for (int i = 0; i < 400; i++) begin
         evt_set   = 15'($urandom) & 15'($urandom);
         reg_wr    = ($urandom % 3) == 0;
         reg_addr  = 1'($urandom);
         reg_wdata = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h0001_FFFF);
         tx_we     = ($urandom % 5) == 0;
         tx_val    = 3'($urandom);
         rx_we     = ($urandom % 5) == 0;
         rx_val    = 3'($urandom);
         cyc();
      end
      cyc(); cyc();
      finish_run();
   end
endmodule